// File: doc/BRIEF.md
# Temperature Compensation Trim Controller

This block turns a digital die-temperature reading into the control word of a DAC that sets the load capacitance of a crystal oscillator. A table holds one trim code for every half degree. The controller reads the two entries on either side of the current reading and blends them linearly in eighths, one eighth for each 1/16 °C step of the reading. It then adds a signed user offset and loads the saturated result into the DAC register.

Work happens only on events. A new cycle starts when the temperature code differs from the one behind the current trim, or when the offset register is written. A freeze input stops temperature updates. While it is set, the last computed trim stays in use and offset writes still recompute the output. The table is a synchronous memory inside the block. It is filled through a write port while the block is held in reset.

Top module: `tcomp_trim_ctrl`

## Requirements
- R1: `temp_code` is a 12-bit two's-complement value in units of 1/16 °C. The table index is floor(temp_code/8) − TBL_BASE, where TBL_BASE defaults to −80 (−40 °C), and frac = temp_code[2:0]. The trim is e0 + floor((e1 − e0)·frac/8), where e0 and e1 are the entries at that index and the next one. Rounding is toward negative infinity.
- R2: When the index is below 0, entry 0 is used as the trim and is not blended.
- R3: When the index is TBL_DEPTH−1 (default 255) or higher, the last entry is used and frac is ignored.
- R4: A cycle starts only when `temp_code` differs from the code behind the current trim, or when `tune_wr` is pulsed. Otherwise `dac_word` holds its value and `done` stays low.
- R5: `tune_val` is a 15-bit two's-complement offset, taken on a `tune_wr` pulse. 0x3FFF means +16383 and 0x4000 means −16384. It is added to the trim.
- R6: The sum is saturated into the unsigned DAC range 0..65535; it never wraps.
- R7: While `comp_hold` is 1, temperature changes start no cycle and the trim is frozen. A `tune_wr` still reloads the DAC with the frozen trim plus the new offset. When `comp_hold` is cleared and the temperature has moved, a cycle runs for the new temperature.
- R8: During reset, `dac_word` is 0, `done` is 0 and the offset is 0. After reset, one cycle runs for the current `temp_code` without any trigger. The code remembered at reset is +25 °C (0x190).
- R9: `done` is a one-cycle pulse. It rises in the cycle after the one in which `dac_word` was loaded. `dac_word` changes only on such loads.
- R10: A `tune_wr` that arrives while a cycle is running is not lost. A further cycle follows that uses the new offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | 12 | Temperature reading, 1/16 °C per LSB, two's complement |
| comp_hold | input | 1 | Freeze the temperature contribution |
| tune_wr | input | 1 | Write strobe for the offset register |
| tune_val | input | 15 | Offset value, two's complement |
| tbl_wr_en | input | 1 | Table write enable |
| tbl_wr_addr | input | 8 | Table write index |
| tbl_wr_data | input | 16 | Table entry (unsigned trim code) |
| dac_word | output | 16 | DAC register |
| done | output | 1 | One-cycle pulse after each DAC load |

## Verification
The bench targets these corner cases:

- **Blend rounding on a falling segment.** A design that truncates toward zero comes out one code high on a falling segment with an odd frac.
- **Negative temperatures.** A design that divides instead of shifting picks the wrong table cell.
- **Both clamp edges, one step inside and one step outside.** A missing clamp reads past the table, and a blend at the last index pulls in a nonexistent neighbour.
- **Both extremes of the offset, pushed against table entries near 0 and near full scale.** A wrapping adder produces a wildly wrong code.
- **The freeze input under temperature motion and offset writes.** A design that still fetches while frozen, or that drops the offset write, shows either a spurious load or no load at all.
- **An offset write during a running cycle.** Without the pending flag, the expected second result is missing.

// File: rtl/tcomp_pkg.sv
package tcomp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_F0,
    ST_F1,
    ST_F2,
    ST_SUM
  } tc_state_e;
endpackage

// File: rtl/tcomp_table_ram.sv
module tcomp_table_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int W     = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tcomp_locate.sv
module tcomp_locate #(
  parameter int TEMP_W = 12,
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int BASE   = -80
) (
  input  logic [TEMP_W-1:0] temp,
  output logic [AW-1:0]     idx0,
  output logic [AW-1:0]     idx1,
  output logic [2:0]        frac
);
  logic signed [31:0] rel;

  always_comb begin
    rel = $signed({{(35-TEMP_W){temp[TEMP_W-1]}}, temp[TEMP_W-1:3]}) - 32'(BASE);
    if (rel < 0) begin
      idx0 = '0;
      idx1 = '0;
      frac = '0;
    end else if (rel >= 32'(DEPTH - 1)) begin
      idx0 = AW'(DEPTH - 1);
      idx1 = AW'(DEPTH - 1);
      frac = '0;
    end else begin
      idx0 = AW'(rel);
      idx1 = AW'(rel) + AW'(1);
      frac = temp[2:0];
    end
  end

  always_comb begin
    AST_IDX_PAIR: assert (idx1 == idx0 || idx1 == idx0 + AW'(1)); // R2
    AST_CLAMP_FRAC: assert (idx1 != idx0 || frac == 3'd0); // R3
  end
endmodule

// File: rtl/tcomp_blend.sv
module tcomp_blend #(
  parameter int TRIM_W = 16
) (
  input  logic [TRIM_W-1:0] e0,
  input  logic [TRIM_W-1:0] e1,
  input  logic [2:0]        frac,
  output logic [TRIM_W-1:0] trim
);
  localparam int PW = TRIM_W + 5;

  logic signed [TRIM_W:0] diff;
  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   step;
  logic signed [PW-1:0]   res;

  always_comb begin
    diff = $signed({1'b0, e1}) - $signed({1'b0, e0});
    prod = $signed({{4{diff[TRIM_W]}}, diff}) * $signed({{(PW-3){1'b0}}, frac});
    step = prod >>> 3;
    res  = $signed({5'b0, e0}) + step;
    trim = res[TRIM_W-1:0];
  end

  always_comb begin
    AST_BLEND_BOUNDS: assert (res >= 0 &&
      ((e1 >= e0) ? (res[TRIM_W-1:0] >= e0 && res[TRIM_W-1:0] <= e1)
                  : (res[TRIM_W-1:0] <= e0 && res[TRIM_W-1:0] >= e1))); // R1
  end
endmodule

// File: rtl/tcomp_trim_ctrl.sv
module tcomp_trim_ctrl
  import tcomp_pkg::*;
#(
  parameter int TEMP_W     = 12,
  parameter int TRIM_W     = 16,
  parameter int TUNE_W     = 15,
  parameter int DAC_W      = 16,
  parameter int TBL_DEPTH  = 256,
  parameter int TBL_BASE   = -80,
  parameter int RESET_TEMP = 400,
  localparam int AW        = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              comp_hold,
  input  logic              tune_wr,
  input  logic [TUNE_W-1:0] tune_val,
  input  logic              tbl_wr_en,
  input  logic [AW-1:0]     tbl_wr_addr,
  input  logic [TRIM_W-1:0] tbl_wr_data,
  output logic [DAC_W-1:0]  dac_word,
  output logic              done
);
  localparam int SUM_W = ((TRIM_W > TUNE_W) ? TRIM_W : TUNE_W) + 2;
  localparam logic signed [SUM_W-1:0] DAC_MAX =
    $signed({{(SUM_W-DAC_W){1'b0}}, {DAC_W{1'b1}}});

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_ff;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_i = rst_ff[1];

  tc_state_e          state_q, state_d;
  logic [TEMP_W-1:0]  last_q, last_d;
  logic [TUNE_W-1:0]  tune_q;
  logic [TRIM_W-1:0]  e0_q, trim_q, trim_d;
  logic [DAC_W-1:0]   dac_q, dac_d;
  logic               init_q, init_d, pend_q, pend_d;
  logic               load_q, done_q;
  logic               start, fetch, rd_en;
  logic [AW-1:0]      idx0, idx1, rd_addr;
  logic [2:0]         frac;
  logic [TRIM_W-1:0]  rd_data, blend;
  logic signed [SUM_W-1:0] sum;

  tcomp_table_ram #(.DEPTH(TBL_DEPTH), .AW(AW), .W(TRIM_W)) u_tbl (
    .clk(clk), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr), .wr_data(tbl_wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  tcomp_locate #(.TEMP_W(TEMP_W), .DEPTH(TBL_DEPTH), .AW(AW), .BASE(TBL_BASE)) u_loc (
    .temp(last_q), .idx0(idx0), .idx1(idx1), .frac(frac)
  );

  tcomp_blend #(.TRIM_W(TRIM_W)) u_blend (
    .e0(e0_q), .e1(rd_data), .frac(frac), .trim(blend)
  );

  // next-state logic
  always_comb begin
    start   = init_q | pend_q | tune_wr | ((temp_code != last_q) & ~comp_hold);
    fetch   = ~comp_hold | init_q;
    state_d = state_q;
    last_d  = last_q;
    init_d  = init_q;
    pend_d  = pend_q;
    trim_d  = trim_q;
    dac_d   = dac_q;
    rd_en   = (state_q == ST_F0) || (state_q == ST_F1);
    rd_addr = (state_q == ST_F0) ? idx0 : idx1;

    sum = $signed({{(SUM_W-TRIM_W){1'b0}}, trim_q}) +
          $signed({{(SUM_W-TUNE_W){tune_q[TUNE_W-1]}}, tune_q});

    if (tune_wr && state_q != ST_IDLE) pend_d = 1'b1;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          init_d  = 1'b0;
          pend_d  = 1'b0;
          state_d = fetch ? ST_F0 : ST_SUM;
          if (fetch) last_d = temp_code;
        end
      end
      ST_F0:   state_d = ST_F1;
      ST_F1:   state_d = ST_F2;
      ST_F2: begin
        trim_d  = blend;
        state_d = ST_SUM;
      end
      ST_SUM: begin
        if (sum[SUM_W-1])      dac_d = '0;
        else if (sum > DAC_MAX) dac_d = '1;
        else                    dac_d = sum[DAC_W-1:0];
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      last_q  <= TEMP_W'(RESET_TEMP);
      init_q  <= 1'b1;
      pend_q  <= 1'b0;
      tune_q  <= '0;
      e0_q    <= '0;
      trim_q  <= '0;
      dac_q   <= '0;
      load_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      last_q  <= last_d;
      init_q  <= init_d;
      pend_q  <= pend_d;
      if (tune_wr)            tune_q <= tune_val;
      if (state_q == ST_F1)   e0_q   <= rd_data;
      trim_q  <= trim_d;
      dac_q   <= dac_d;
      load_q  <= (state_q == ST_SUM);
      done_q  <= load_q;
    end
  end

  assign dac_word = dac_q;
  assign done     = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_i)
    done_q |=> !done_q); // R9
  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_i)
    done_q |-> $past(state_q == ST_SUM, 2)); // R9
  AST_DAC_STABLE: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q != ST_SUM) |=> $stable(dac_q)); // R4
  AST_HOLD_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_IDLE && comp_hold && !init_q) |=> (state_q != ST_F0)); // R7
  AST_TRIM_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q != ST_F2) |=> $stable(trim_q)); // R7
endmodule

// File: tb/tb_tcomp_trim_ctrl.sv
module tb_tcomp_trim_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] temp_code;
  logic        comp_hold;
  logic        tune_wr;
  logic [14:0] tune_val;
  logic        tbl_wr_en;
  logic [7:0]  tbl_wr_addr;
  logic [15:0] tbl_wr_data;
  logic [15:0] dac_word;
  logic        done;

  int tb_tbl [256];
  int exp_q[$];
  string tag_q[$];
  int checks = 0;
  int fails  = 0;
  int cur_tune = 0;
  int trim_temp = 400;
  bit prev_done = 1'b0;

  always #2.5 clk = ~clk;

  tcomp_trim_ctrl dut (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .comp_hold(comp_hold),
    .tune_wr(tune_wr), .tune_val(tune_val), .tbl_wr_en(tbl_wr_en),
    .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .dac_word(dac_word), .done(done)
  );

  function automatic int model(int t, int tune);
    int raw, rel, fr, tr, s;
    raw = t >>> 3;
    rel = raw + 80;
    fr  = t & 7;
    if (rel < 0)         tr = tb_tbl[0];
    else if (rel >= 255) tr = tb_tbl[255];
    else                 tr = tb_tbl[rel] + (((tb_tbl[rel+1] - tb_tbl[rel]) * fr) >>> 3);
    s = tr + tune;
    if (s < 0) s = 0;
    if (s > 65535) s = 65535;
    return s;
  endfunction

  function automatic int sext15(int v);
    return (v >= 16384) ? v - 32768 : v;
  endfunction

  task automatic push(int v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic set_temp(int t, string tag, bit expect_it);
    @(negedge clk);
    temp_code = t[11:0];
    if (expect_it) begin
      trim_temp = t;
      push(model(t, cur_tune), tag);
    end
  endtask

  task automatic write_tune(int v, string tag);
    @(negedge clk);
    tune_wr  = 1'b1;
    tune_val = v[14:0];
    cur_tune = sext15(v);
    push(model(trim_temp, cur_tune), tag);
    @(negedge clk);
    tune_wr = 1'b0;
  endtask

  task automatic check_quiet(string tag);
    logic [15:0] held;
    held = dac_word;
    repeat (30) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || dac_word != held) begin
      fails++;
      $display("FAIL %s: dac_word=%0d expected %0d (no update)", tag, dac_word, held);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        checks++;
        if (prev_done) begin
          fails++;
          $display("FAIL R9: done high 2 cycles, actual 1 expected 0");
        end
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R4: unexpected load, dac_word=%0d expected none", dac_word);
        end else begin
          int e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (dac_word !== e[15:0]) begin
            fails++;
            $display("FAIL %s: dac_word=%0d expected %0d", tg, dac_word, e);
          end
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) tb_tbl[i] = 30000 + ((i * 1237) % 4001);
    tb_tbl[0]   = 16;
    tb_tbl[255] = 65520;
    rst_n = 1'b0; temp_code = 12'h190; comp_hold = 1'b0; tune_wr = 1'b0;
    tune_val = '0; tbl_wr_en = 1'b0; tbl_wr_addr = '0; tbl_wr_data = '0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_addr = i[7:0]; tbl_wr_data = tb_tbl[i][15:0];
    end
    @(negedge clk);
    tbl_wr_en = 1'b0;
    checks++;
    if (dac_word !== 16'd0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R8: reset dac=%0d done=%0b expected 0 0", dac_word, done);
    end
    // R8: automatic cycle after reset at 25 C
    push(model(400, 0), "R8");
    @(negedge clk);
    rst_n = 1'b1;
    drain();

    // R1: blends, incl. falling segment with floor rounding and negative temps
    set_temp(405, "R1", 1); drain();
    set_temp(419, "R1", 1); drain();
    set_temp(-35, "R1", 1); drain();
    set_temp(-1,  "R1", 1); drain();
    set_temp(1000, "R1", 1); drain();

    // R4: same code again -> no cycle
    set_temp(1000, "R4", 0);
    check_quiet("R4");

    // R2: lower clamp
    set_temp(-633, "R2", 1); drain();
    set_temp(-640, "R2", 1); drain();
    set_temp(-641, "R2", 1); drain();
    set_temp(-2048, "R2", 1); drain();

    // R3: upper clamp
    set_temp(1399, "R3", 1); drain();
    set_temp(1400, "R3", 1); drain();
    set_temp(1407, "R3", 1); drain();
    set_temp(2047, "R3", 1); drain();

    // R5 / R6: offset extremes and saturation
    write_tune(16'h3FFF, "R6"); drain();
    set_temp(-2048, "R5", 1); drain();
    write_tune(16'h4000, "R6"); drain();
    set_temp(405, "R5", 1); drain();
    write_tune(16'h0005, "R5"); drain();
    write_tune(16'h7FFB, "R5"); drain();

    // R7: freeze
    @(negedge clk); comp_hold = 1'b1;
    set_temp(600, "R7", 0);
    check_quiet("R7");
    write_tune(16'h0100, "R7"); drain();
    set_temp(700, "R7", 0);
    check_quiet("R7");
    @(negedge clk);
    comp_hold = 1'b0;
    trim_temp = 700;
    push(model(700, cur_tune), "R7");
    drain();

    // R10: offset write during a running cycle
    @(negedge clk);
    temp_code = 12'd300;
    trim_temp = 300;
    @(negedge clk);
    tune_wr = 1'b1; tune_val = 15'h0020; cur_tune = 32;
    push(model(300, 32), "R10");
    push(model(300, 32), "R10");
    @(negedge clk);
    tune_wr = 1'b0;
    drain();
    check_quiet("R9");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule